// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block conditions one active-low external interrupt pin and turns it into an interrupt request for the processor. It synchronises the raw pin into the clock domain. Software can choose between low-level recognition and falling-edge recognition, and it can connect or disconnect the pin from the request logic. A byte-wide register bus with an address, a write strobe, write data and combinational read data carries the configuration.

A mode input separates special operation from normal operation. In normal operation, the recognition choice is protected by a lock that closes on the first configuration write. In special operation, the choice stays writable at all times. In edge mode, a captured falling edge is held until reset or until the interrupt-acknowledge input is pulsed. The address just above the control register is reserved.

Top module: `extint_ctrl`

## Requirements
- R1: After reset, the control register (default address 14) reads 0x40 (edge mode off, pin connected) and `irq_req` is 0.
- R2: Bits 5..0 of the control register always read 0, and writing ones to them changes nothing.
- R3: Bit 6 (enable) can be written in any mode at any time. While it is 0, `irq_req` stays 0 whatever the pin does.
- R4: In normal mode (`special_mode`=0), bit 7 (edge mode) takes only the first control write after reset. Later writes leave bit 7 unchanged.
- R5: In special mode (`special_mode`=1), bit 7 takes every control write.
- R6: In level mode with enable set, `irq_req` is 1 while the synchronised pin is low and 0 while it is high. It follows the pin within four clocks.
- R7: In edge mode with enable set, a falling edge on the pin raises `irq_req`. The request stays at 1 after the pin returns high.
- R8: A one-cycle pulse on `svc_ack` clears a captured edge, so `irq_req` returns to 0 while the pin stays high.
- R9: When a newly detected falling edge and an `svc_ack` pulse fall in the same cycle, the edge is kept and `irq_req` stays 1.
- R10: The reserved address (control address + 1, default 15) reads 0x00. Writes to it leave the control register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| special_mode | input | 1 | 1 = special operation (bit 7 always writable) |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pin_n | input | 1 | Raw active-low interrupt pin |
| svc_ack | input | 1 | Interrupt serviced, clears the captured edge |
| irq_req | output | 1 | Interrupt request |

## Verification
Edge detection and the service acknowledge can land in the same cycle, and the edge must win. The bench provokes this by counting the synchroniser delay after a falling pin. It raises `svc_ack` for exactly the cycle in which the synchronised fall appears. It judges the result from `irq_req` a few cycles later: the request must still be high. A separate service pulse on a quiet pin must then drop the request.

// File: rtl/extint_pkg.sv
package extint_pkg;
   localparam int DATA_W  = 8;
   localparam int EDGE_POS = 7;
   localparam int EN_POS   = 6;

   typedef struct packed {
      logic edge_mode;
      logic enable;
   } extint_cfg_t;

   localparam extint_cfg_t CFG_RESET = '{edge_mode: 1'b0, enable: 1'b1};
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain <= RESET_VAL;
            else        chain <= d;
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain <= {STAGES{RESET_VAL}};
            else        chain <= {chain[STAGES-2:0], d};
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/extint_cfg.sv
module extint_cfg
   import extint_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              special_mode,
   input  logic              wr_ctrl,
   input  logic [DATA_W-1:0] wdata,
   output extint_cfg_t       cfg,
   output logic              lock
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg  <= CFG_RESET;
         lock <= 1'b0;
      end else if (wr_ctrl) begin
         cfg.enable <= wdata[EN_POS];
         if (special_mode) begin
            cfg.edge_mode <= wdata[EDGE_POS];
         end else if (!lock) begin
            cfg.edge_mode <= wdata[EDGE_POS];
            lock          <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/extint_detect.sv
module extint_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_n,
   input  logic edge_mode,
   input  logic enable,
   input  logic svc_ack,
   output logic fall,
   output logic latch,
   output logic irq
);
   logic prev_n;

   assign fall = prev_n & ~sync_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_n <= 1'b1;
         latch  <= 1'b0;
         irq    <= 1'b0;
      end else begin
         prev_n <= sync_n;
         if (edge_mode && fall) latch <= 1'b1;
         else if (svc_ack)      latch <= 1'b0;
         irq <= enable & (edge_mode ? latch : ~sync_n);
      end
   end
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
   import extint_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int CTRL_ADDR   = 14,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              special_mode,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              pin_n,
   input  logic              svc_ack,
   output logic              irq_req
);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] RSVD_A = ADDR_W'(CTRL_ADDR + 1);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("extint_ctrl: SYNC_STAGES must be at least 2");
      end
      if (CTRL_ADDR + 1 >= (1 << ADDR_W)) begin : g_bad_addr
         $error("extint_ctrl: reserved address does not fit ADDR_W");
      end
   endgenerate

   extint_cfg_t cfg;
   logic        lock;
   logic        sync_n;
   logic        fall;
   logic        latch;
   logic        wr_ctrl;

   assign wr_ctrl = bus_wr && (bus_addr == CTRL_A);

   extint_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) sync_i (
      .clk(clk), .rst_n(rst_n), .d(pin_n), .q(sync_n));

   extint_cfg cfg_i (
      .clk(clk), .rst_n(rst_n), .special_mode(special_mode),
      .wr_ctrl(wr_ctrl), .wdata(bus_wdata), .cfg(cfg), .lock(lock));

   extint_detect det_i (
      .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .edge_mode(cfg.edge_mode),
      .enable(cfg.enable), .svc_ack(svc_ack), .fall(fall), .latch(latch),
      .irq(irq_req));

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == CTRL_A) begin
         bus_rdata[EDGE_POS] = cfg.edge_mode;
         bus_rdata[EN_POS]   = cfg.enable;
      end
   end
   // RSVD_A and all other addresses read zero; writes there are not decoded.
   logic unused_rsvd;
   assign unused_rsvd = ^RSVD_A;
endmodule

// File: rtl/extint_ctrl_chk.sv
module extint_ctrl_chk #(
   parameter int ADDR_W    = 4,
   parameter int CTRL_ADDR = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              special_mode,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [7:0]        bus_rdata,
   input logic              irq_req,
   input logic              enable,
   input logic              edge_mode,
   input logic              lock,
   input logic              sync_n,
   input logic              fall,
   input logic              latch
);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] RSVD_A = ADDR_W'(CTRL_ADDR + 1);

   assert_low_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == CTRL_A) |-> (bus_rdata[5:0] == 6'd0));

   assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !irq_req);

   assert_edge_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && !special_mode) |=> $stable(edge_mode));

   assert_level_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !edge_mode) |=> (irq_req == !$past(sync_n)));

   assert_edge_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && edge_mode) |=> latch);

   assert_rsvd_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == RSVD_A) |-> (bus_rdata == 8'h00));
endmodule

bind extint_ctrl extint_ctrl_chk #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) chk_i (
   .clk(clk), .rst_n(rst_n), .special_mode(special_mode), .bus_addr(bus_addr),
   .bus_rdata(bus_rdata), .irq_req(irq_req), .enable(cfg.enable),
   .edge_mode(cfg.edge_mode), .lock(lock), .sync_n(sync_n), .fall(fall),
   .latch(latch));

// File: tb/extint_ctrl_tb.sv
`timescale 1ns/1ps
module extint_ctrl_tb_top;
   localparam int AW = 4;
   localparam logic [AW-1:0] CA = 4'd14;
   localparam logic [AW-1:0] RA = 4'd15;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic special_mode = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic pin_n = 1'b1;
   logic svc_ack = 1'b0;
   logic irq_req;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   extint_ctrl #(.ADDR_W(AW), .CTRL_ADDR(14), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .special_mode(special_mode), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_n(pin_n), .svc_ack(svc_ack), .irq_req(irq_req));

   function automatic logic [7:0] ctrl_image(input logic edge_b, input logic en_b);
      return {edge_b, en_b, 6'b0};
   endfunction

   function automatic logic level_irq(input logic en_b, input logic pin_b);
      return en_b & ~pin_b;
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_check(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
      @(negedge clk);
      bus_addr = a;
      #1;
      check(req, bus_rdata, exp);
   endtask

   task automatic svc_pulse();
      @(negedge clk); svc_ack = 1'b1;
      @(negedge clk); svc_ack = 1'b0;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic exp_edge, exp_en;
      void'($urandom(32'h1E57));
      cyc(3);
      rst_n = 1'b1;
      cyc(2);
      // R1 reset state
      rd_check("R1", CA, 8'h40);
      check("R1", {7'b0, irq_req}, 8'h00);
      // R10 reserved reads zero
      rd_check("R10", RA, 8'h00);
      // normal mode: first write locks edge bit; R2 low bits ignored
      wr(CA, 8'hFF);
      rd_check("R2", CA, 8'hC0);
      wr(CA, 8'h40);
      rd_check("R4", CA, 8'hC0);
      wr(CA, 8'h00);
      rd_check("R3", CA, 8'h80);
      wr(RA, 8'hFF);
      rd_check("R10", CA, 8'h80);
      rd_check("R10", RA, 8'h00);
      wr(CA, 8'hC0);
      rd_check("R4", CA, 8'hC0);
      // R7 edge capture held after pin returns high
      pin_n = 1'b1; cyc(4); svc_pulse(); cyc(3);
      check("R7", {7'b0, irq_req}, 8'h00);
      pin_n = 1'b0; cyc(2); pin_n = 1'b1; cyc(5);
      check("R7", {7'b0, irq_req}, 8'h01);
      // R8 service clears
      svc_pulse(); cyc(3);
      check("R8", {7'b0, irq_req}, 8'h00);
      // R9 edge and service in the same cycle
      @(negedge clk); pin_n = 1'b0;
      @(posedge clk); @(posedge clk);
      @(negedge clk); svc_ack = 1'b1;
      @(negedge clk); svc_ack = 1'b0;
      pin_n = 1'b1; cyc(3);
      check("R9", {7'b0, irq_req}, 8'h01);
      svc_pulse(); cyc(3);
      check("R8", {7'b0, irq_req}, 8'h00);
      // R3 disabled: edge does not request
      wr(CA, 8'h80);
      pin_n = 1'b0; cyc(3); pin_n = 1'b1; cyc(5);
      check("R3", {7'b0, irq_req}, 8'h00);
      svc_pulse();
      // R5 special mode: edge bit writable freely
      special_mode = 1'b1;
      wr(CA, 8'h40);
      rd_check("R5", CA, 8'h40);
      wr(CA, 8'hC0);
      rd_check("R5", CA, 8'hC0);
      // random configuration writes in special mode
      for (int k = 0; k < 20; k++) begin
         logic [7:0] d;
         d = 8'($urandom());
         wr(CA, d);
         rd_check("R5", CA, ctrl_image(d[7], d[6]));
      end
      // R6 random level-mode traffic
      wr(CA, 8'h40);
      exp_edge = 1'b0; exp_en = 1'b1;
      for (int k = 0; k < 40; k++) begin
         logic p, e;
         p = 1'($urandom());
         e = 1'($urandom_range(0, 3) != 0);
         if (e != exp_en) begin
            wr(CA, ctrl_image(exp_edge, e));
            exp_en = e;
         end
         @(negedge clk); pin_n = p;
         cyc(4);
         check(e ? "R6" : "R3", {7'b0, irq_req}, {7'b0, level_irq(exp_en, p)});
      end
      pin_n = 1'b1;
      cyc(3);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule